// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This block moves the bytes of a configuration item between the item store and system memory under the control of one descriptor in memory. Software writes the 64-bit memory address of the descriptor into an address register, as two 32-bit halves or as one 64-bit word. The write that completes the address starts the transfer. The engine reads the big-endian descriptor and may switch the item store to a new selector. It then reads, writes or skips over the requested number of bytes. When it finishes, it writes a status word over the descriptor's control field.

The descriptor holds four 32-bit big-endian words:

| Byte offset | Contents |
|---|---|
| 0 | control |
| 4 | length |
| 8 | target address, upper half |
| 12 | target address, lower half |

The engine talks to memory through a request/acknowledge port. Descriptor fetch and status write-back use 32-bit words; data moves one byte at a time. Reading the address register returns lanes of a fixed 64-bit identification constant.

The state machine has eight states:

| State | Role |
|---|---|
| ST_IDLE | waiting for a trigger |
| ST_FETCH | the four descriptor word reads |
| ST_SELECT | the optional selector strobe and operation decode |
| ST_PLAN | the up-front write admission check |
| ST_STEP | per-byte decision |
| ST_MEM_WR | storing one byte to memory |
| ST_MEM_RD | loading one byte from memory |
| ST_WBACK | the status word write |

The transitions are:
- ST_IDLE→ST_FETCH on a trigger.
- ST_FETCH repeats until the fourth acknowledge, then moves to ST_SELECT. A memory error here goes to ST_WBACK instead.
- ST_SELECT→ST_PLAN.
- ST_PLAN→ST_STEP, or ST_PLAN→ST_WBACK on a rejected write.
- ST_STEP→ST_MEM_WR for a read, ST_STEP→ST_MEM_RD for a write, and ST_STEP→ST_STEP for a skip. It goes to ST_WBACK when the length reaches zero or when a write finds no item bytes.
- ST_MEM_WR and ST_MEM_RD return to ST_STEP on acknowledge, or go to ST_WBACK on a memory error.
- ST_WBACK→ST_IDLE on acknowledge.

Top module: `cfgdma_engine`

## Requirements
- R1: A 4-byte register write at offset 0 loads bits 63:32 of the address register and clears bits 31:0. A 4-byte write at offset 4 ORs its value into bits 31:0 and starts a transfer from that address. `busy` is high from the next cycle.
- R2: An 8-byte write at offset 0 starts a transfer at the full 64-bit value. A write of any other size/offset pair leaves the engine idle and the address register unchanged.
- R3: A register read of size S (1, 2, 4 or 8) at offset O returns bytes O to O+S-1 of the big-endian constant 0x51454D5520434647, right-aligned on `reg_rdata`, one cycle after `reg_rd`. If O+S exceeds 8 or the size is not one of these, the read returns zero.
- R4: The descriptor is read as four word requests at base, base+4, base+8 and base+12. Each word is big-endian, so bits 31:24 hold the byte at the lowest address. The words hold control, length, target address bits 63:32 and target address bits 31:0.
- R5: When control bit 3 (select) is set, `itm_sel_stb` pulses with `itm_sel_key` equal to control bits 31:16 before any data byte moves.
- R6: Control bit 1 (read) outranks bit 4 (write), which outranks bit 2 (skip). With none of the three set, the length is taken as zero and the status is 0.
- R7: A read copies item bytes to consecutive memory addresses from the target address on, one byte per request in bits 7:0. Once the item is exhausted or invalid, it stores zero bytes for the rest of the length.
- R8: A skip advances the item offset by the length, or until the item ends, and makes no memory data access.
- R9: A write copies memory bytes into the item. It fails with status 1 and leaves the item unchanged if the item is read-only, if the length exceeds the bytes left in the item, or if the item is exhausted or invalid.
- R10: On completion, the engine writes the word 0 (success) or 1 (error) to the descriptor base address. If a descriptor word read reports an error, the engine writes 1 without any item access.
- R11: The address register clears when a transfer starts. Register writes while `busy` is high are ignored.
- R12: A memory error on a data byte stops the transfer with status 1. Bytes already moved stay moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_off | input | 3 | Byte offset of the register access |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Write data, right-aligned |
| reg_rdata | output | 64 | Read data, valid the cycle after `reg_rd` |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory request is a store |
| mem_word | output | 1 | 1: 32-bit big-endian word, 0: single byte in bits 7:0 |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | One-cycle completion of the request |
| mem_err | input | 1 | Error with `mem_ack` |
| mem_rdata | input | 32 | Load data with `mem_ack` |
| itm_sel_stb | output | 1 | Select a new item, resetting its offset |
| itm_sel_key | output | 16 | Selector for `itm_sel_stb` |
| itm_rd_stb | output | 1 | Consume the current item byte |
| itm_wr_stb | output | 1 | Store `itm_wdata` at the current offset and advance |
| itm_wdata | output | 8 | Byte to store into the item |
| itm_valid | input | 1 | Current selector names an existing item |
| itm_writable | input | 1 | Current item accepts writes |
| itm_remain | input | 32 | Bytes left in the current item |
| itm_rdata | input | 8 | Byte at the current item offset |

## Verification
A register read result is due one cycle after the read strobe. The bench raises the strobe at a falling edge and samples at the following falling edge. A start is visible as `busy` one edge after the triggering write. The bench confirms ignored writes by sampling `busy` a falling edge after the write. Transfer results land in memory or in the item only at a data-dependent cycle, so the bench polls `busy` at falling edges and compares memory bytes, item bytes and the written-back status only after `busy` has dropped. The bench memory acknowledges each request one cycle after it sees it and leaves an idle cycle between acknowledges, which exercises the request-hold rule.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
    localparam int unsigned ADDR_W = 64;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned KEY_W  = 16;
    localparam int unsigned BYTE_W = 8;

    localparam logic [63:0] ID_CONST = 64'h5145_4D55_2043_4647;

    localparam int unsigned FL_READ  = 1;
    localparam int unsigned FL_SKIP  = 2;
    localparam int unsigned FL_SEL   = 3;
    localparam int unsigned FL_WRITE = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_SELECT, ST_PLAN,
        ST_STEP, ST_MEM_RD, ST_MEM_WR, ST_WBACK
    } dma_state_e;

    typedef enum logic [1:0] {OP_NONE, OP_SKIP, OP_WRITE, OP_READ} dma_op_e;

    function automatic dma_op_e decode_op(input logic [4:1] fl);
        if (fl[FL_READ])       return OP_READ;
        else if (fl[FL_WRITE]) return OP_WRITE;
        else if (fl[FL_SKIP])  return OP_SKIP;
        else                   return OP_NONE;
    endfunction
endpackage

// File: rtl/cfgdma_regs.sv
module cfgdma_regs
    import cfgdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_off,
    input  logic [3:0]        reg_size,
    input  logic [63:0]       reg_wdata,
    input  logic              busy,
    output logic [63:0]       reg_rdata,
    output logic              start,
    output logic [ADDR_W-1:0] start_addr
);
    localparam int unsigned HALF = ADDR_W / 2;

    logic [ADDR_W-1:0] addr_q;
    logic              wr_hi, wr_lo, wr_full;
    logic [4:0]        end_b;
    logic              rd_ok;
    logic [63:0]       rd_mask, rd_val;

    assign wr_hi   = reg_wr && reg_size == 4'd4 && reg_off == 3'd0;
    assign wr_lo   = reg_wr && reg_size == 4'd4 && reg_off == 3'd4;
    assign wr_full = reg_wr && reg_size == 4'd8 && reg_off == 3'd0;
    assign start   = !busy && (wr_lo || wr_full);
    assign start_addr = wr_full ? reg_wdata
                                : (addr_q | {{HALF{1'b0}}, reg_wdata[HALF-1:0]});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else if (start)
            addr_q <= '0;
        else if (wr_hi && !busy)
            addr_q <= {reg_wdata[HALF-1:0], {HALF{1'b0}}};
    end

    always_comb begin
        end_b = {2'b00, reg_off} + {1'b0, reg_size};
        unique case (reg_size)
            4'd1:    begin rd_mask = 64'h0000_0000_0000_00FF; rd_ok = 1'b1; end
            4'd2:    begin rd_mask = 64'h0000_0000_0000_FFFF; rd_ok = 1'b1; end
            4'd4:    begin rd_mask = 64'h0000_0000_FFFF_FFFF; rd_ok = 1'b1; end
            4'd8:    begin rd_mask = '1;                      rd_ok = 1'b1; end
            default: begin rd_mask = '0;                      rd_ok = 1'b0; end
        endcase
        if (end_b > 5'd8) rd_ok = 1'b0;
        rd_val = (ID_CONST >> {(5'd8 - end_b), 3'b000}) & rd_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_ok ? rd_val : '0;
    end
endmodule

// File: rtl/cfgdma_fsm.sv
module cfgdma_fsm
    import cfgdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              itm_sel_stb,
    output logic [KEY_W-1:0]  itm_sel_key,
    output logic              itm_rd_stb,
    output logic              itm_wr_stb,
    output logic [BYTE_W-1:0] itm_wdata,
    input  logic              itm_valid,
    input  logic              itm_writable,
    input  logic [WORD_W-1:0] itm_remain,
    input  logic [BYTE_W-1:0] itm_rdata
);
    dma_state_e        state_q, state_d;
    dma_op_e           op_q;
    logic [1:0]        idx_q;
    logic [KEY_W-1:0]  key_q;
    logic [4:1]        flags_q;
    logic [WORD_W-1:0] len_q;
    logic [ADDR_W-1:0] dst_q, base_q;
    logic [BYTE_W-1:0] data_q;
    logic              err_q;
    logic              have_bytes, write_reject;

    assign have_bytes   = itm_valid && (itm_remain != '0);
    assign write_reject = op_q == OP_WRITE && len_q != '0 && have_bytes &&
                          (!itm_writable || len_q > itm_remain);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_FETCH;
            ST_FETCH:  if (mem_ack) begin
                           if (mem_err)            state_d = ST_WBACK;
                           else if (idx_q == 2'd3) state_d = ST_SELECT;
                       end
            ST_SELECT: state_d = ST_PLAN;
            ST_PLAN:   state_d = write_reject ? ST_WBACK : ST_STEP;
            ST_STEP: begin
                if (len_q == '0) state_d = ST_WBACK;
                else begin
                    unique case (op_q)
                        OP_READ:  state_d = ST_MEM_WR;
                        OP_WRITE: state_d = have_bytes ? ST_MEM_RD : ST_WBACK;
                        OP_SKIP:  state_d = ST_STEP;
                        default:  state_d = ST_WBACK;
                    endcase
                end
            end
            ST_MEM_RD, ST_MEM_WR:
                if (mem_ack) state_d = mem_err ? ST_WBACK : ST_STEP;
            ST_WBACK:  if (mem_ack) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_NONE; idx_q <= '0; key_q <= '0; flags_q <= '0;
            len_q <= '0; dst_q <= '0; base_q <= '0; data_q <= '0; err_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    base_q <= start_addr; idx_q <= '0; err_q <= 1'b0;
                end
                ST_FETCH: if (mem_ack) begin
                    if (mem_err) err_q <= 1'b1;
                    else begin
                        unique case (idx_q)
                            2'd0: begin key_q <= mem_rdata[31:16]; flags_q <= mem_rdata[4:1]; end
                            2'd1: len_q <= mem_rdata;
                            2'd2: dst_q[63:32] <= mem_rdata;
                            default: dst_q[31:0] <= mem_rdata;
                        endcase
                        idx_q <= idx_q + 2'd1;
                    end
                end
                ST_SELECT: begin
                    op_q <= decode_op(flags_q);
                    if (decode_op(flags_q) == OP_NONE) len_q <= '0;
                end
                ST_PLAN: if (write_reject) err_q <= 1'b1;
                ST_STEP: if (len_q != '0) begin
                    unique case (op_q)
                        OP_READ:  data_q <= have_bytes ? itm_rdata : '0;
                        OP_SKIP:  len_q <= len_q - 1'b1;
                        OP_WRITE: if (!have_bytes) err_q <= 1'b1;
                        default:  ;
                    endcase
                end
                ST_MEM_RD, ST_MEM_WR: if (mem_ack) begin
                    if (mem_err) err_q <= 1'b1;
                    else begin
                        len_q <= len_q - 1'b1;
                        dst_q <= dst_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy        = state_q != ST_IDLE;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_word    = 1'b0;
        mem_addr    = dst_q;
        mem_wdata   = {{(WORD_W-BYTE_W){1'b0}}, data_q};
        itm_sel_stb = 1'b0;
        itm_sel_key = key_q;
        itm_rd_stb  = 1'b0;
        itm_wr_stb  = 1'b0;
        itm_wdata   = mem_rdata[BYTE_W-1:0];
        unique case (state_q)
            ST_FETCH: begin
                mem_req = 1'b1; mem_word = 1'b1;
                mem_addr = base_q + {{(ADDR_W-4){1'b0}}, idx_q, 2'b00};
            end
            ST_SELECT: itm_sel_stb = flags_q[FL_SEL];
            ST_STEP:   itm_rd_stb = len_q != '0 && have_bytes &&
                                    (op_q == OP_READ || op_q == OP_SKIP);
            ST_MEM_RD: begin
                mem_req = 1'b1;
                itm_wr_stb = mem_ack && !mem_err;
            end
            ST_MEM_WR: begin mem_req = 1'b1; mem_we = 1'b1; end
            ST_WBACK: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_word = 1'b1;
                mem_addr = base_q;
                mem_wdata = {{(WORD_W-1){1'b0}}, err_q};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
    import cfgdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_off,
    input  logic [3:0]        reg_size,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              itm_sel_stb,
    output logic [KEY_W-1:0]  itm_sel_key,
    output logic              itm_rd_stb,
    output logic              itm_wr_stb,
    output logic [BYTE_W-1:0] itm_wdata,
    input  logic              itm_valid,
    input  logic              itm_writable,
    input  logic [WORD_W-1:0] itm_remain,
    input  logic [BYTE_W-1:0] itm_rdata
);
    logic              start;
    logic [ADDR_W-1:0] start_addr;

    cfgdma_regs i_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_off(reg_off), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .busy(busy), .reg_rdata(reg_rdata), .start(start), .start_addr(start_addr)
    );

    cfgdma_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .mem_rdata(mem_rdata), .itm_sel_stb(itm_sel_stb),
        .itm_sel_key(itm_sel_key), .itm_rd_stb(itm_rd_stb), .itm_wr_stb(itm_wr_stb),
        .itm_wdata(itm_wdata), .itm_valid(itm_valid), .itm_writable(itm_writable),
        .itm_remain(itm_remain), .itm_rdata(itm_rdata)
    );
endmodule

// File: rtl/cfgdma_engine_chk.sv
module cfgdma_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [2:0]  reg_off,
    input logic [3:0]  reg_size,
    input logic        busy,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_word,
    input logic [63:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        itm_sel_stb,
    input logic        itm_rd_stb,
    input logic        itm_wr_stb,
    input logic        itm_valid,
    input logic        itm_writable,
    input logic [31:0] itm_remain
);
    logic trig;
    assign trig = reg_size == 4'd8 ? reg_off == 3'd0 :
                  (reg_size == 4'd4 && reg_off == 3'd4);

    a_r1_low_half_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !busy && reg_size == 4'd4 && reg_off == 3'd4) |=> busy);

    a_r2_other_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !busy && !trig) |=> !busy);

    a_r4_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r9_write_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
        itm_wr_stb |-> (itm_valid && itm_writable && itm_remain != 32'd0));

    a_r10_status_value: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_word) |-> (mem_wdata <= 32'd1));

    a_r11_mem_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    a_r11_item_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (itm_sel_stb || itm_rd_stb || itm_wr_stb) |-> busy);

    a_r8_one_item_op: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({itm_sel_stb, itm_rd_stb, itm_wr_stb}));
endmodule

bind cfgdma_engine cfgdma_engine_chk i_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
    .reg_size(reg_size), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .itm_sel_stb(itm_sel_stb), .itm_rd_stb(itm_rd_stb),
    .itm_wr_stb(itm_wr_stb), .itm_valid(itm_valid), .itm_writable(itm_writable),
    .itm_remain(itm_remain)
);

// File: tb/test_cfgdma_engine.sv
`timescale 1ns/1ps
module test_cfgdma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_off = '0;
    logic [3:0]  reg_size = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        busy, mem_req, mem_we, mem_word;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        itm_sel_stb, itm_rd_stb, itm_wr_stb;
    logic [15:0] itm_sel_key;
    logic [7:0]  itm_wdata;
    logic        itm_valid, itm_writable;
    logic [31:0] itm_remain;
    logic [7:0]  itm_rdata;

    int n_checks = 0, n_errors = 0;

    logic [7:0]  bmem [0:255];
    logic [7:0]  imem [0:3][0:7];
    int          ilen [0:3];
    bit          iwr  [0:3];
    logic [15:0] cur_key = 16'd0;
    int          cur_off = 0;

    always #10 clk = ~clk;

    cfgdma_engine i_cfgdma_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_off(reg_off), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .itm_sel_stb(itm_sel_stb), .itm_sel_key(itm_sel_key),
        .itm_rd_stb(itm_rd_stb), .itm_wr_stb(itm_wr_stb), .itm_wdata(itm_wdata),
        .itm_valid(itm_valid), .itm_writable(itm_writable),
        .itm_remain(itm_remain), .itm_rdata(itm_rdata)
    );

    // item store model
    assign itm_valid    = cur_key < 16'd4;
    assign itm_writable = itm_valid && iwr[cur_key[1:0]];
    assign itm_remain   = itm_valid ? 32'(ilen[cur_key[1:0]] - cur_off) : 32'd0;
    assign itm_rdata    = (itm_valid && cur_off < 8) ? imem[cur_key[1:0]][cur_off[2:0]] : 8'h00;

    always @(posedge clk) begin
        if (itm_sel_stb) begin
            cur_key <= itm_sel_key;
            cur_off <= 0;
        end else if (itm_rd_stb) begin
            cur_off <= cur_off + 1;
        end else if (itm_wr_stb) begin
            imem[cur_key[1:0]][cur_off[2:0]] <= itm_wdata;
            cur_off <= cur_off + 1;
        end
    end

    // memory model: bytes at 0x00..0xFF exist, anything else errors
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0; mem_err = 1'b0;
            end else if (mem_req) begin
                mem_ack = 1'b1;
                mem_err = (mem_addr[63:8] != 0) || (mem_word && mem_addr[7:0] > 8'd252);
                if (!mem_err) begin
                    if (mem_we && mem_word) begin
                        for (int k = 0; k < 4; k++)
                            bmem[mem_addr[7:0] + k] = mem_wdata[31-8*k -: 8];
                    end else if (mem_we) begin
                        bmem[mem_addr[7:0]] = mem_wdata[7:0];
                    end else if (mem_word) begin
                        for (int k = 0; k < 4; k++)
                            mem_rdata[31-8*k -: 8] = bmem[mem_addr[7:0] + k];
                    end else begin
                        mem_rdata = {24'h0, bmem[mem_addr[7:0]]};
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put_word(input int a, input logic [31:0] w);
        for (int k = 0; k < 4; k++) bmem[a + k] = w[31-8*k -: 8];
    endtask

    function automatic logic [31:0] get_word(input int a);
        return {bmem[a], bmem[a+1], bmem[a+2], bmem[a+3]};
    endfunction

    task automatic put_desc(input int base, input logic [31:0] ctl, input logic [31:0] len, input logic [31:0] dst);
        put_word(base, ctl); put_word(base + 4, len);
        put_word(base + 8, 32'h0); put_word(base + 12, dst);
    endtask

    task automatic reg_write(input logic [2:0] off, input logic [3:0] size, input logic [63:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_off = off; reg_size = size; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] off, input logic [3:0] size, output logic [63:0] val);
        @(negedge clk);
        reg_rd = 1'b1; reg_off = off; reg_size = size;
        @(negedge clk);
        reg_rd = 1'b0;
        val = reg_rdata;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 3000) begin @(negedge clk); n++; end
        chk(req, "transfer completes", {63'd0, busy}, 64'd0);
    endtask

    task automatic fill(input int a, input int n, input logic [7:0] v);
        for (int k = 0; k < n; k++) bmem[a + k] = v;
    endtask

    localparam logic [31:0] C_RD = 32'h02, C_SK = 32'h04, C_SL = 32'h08, C_WR = 32'h10;

    task automatic t_reset();
        chk("R11", "busy after reset", {63'd0, busy}, 64'd0);
        chk("R11", "no mem request after reset", {63'd0, mem_req}, 64'd0);
        chk("R3", "rdata after reset", reg_rdata, 64'd0);
    endtask

    task automatic t_signature();
        logic [63:0] v;
        reg_read(3'd0, 4'd8, v); chk("R3", "8B@0", v, 64'h5145_4D55_2043_4647);
        reg_read(3'd4, 4'd4, v); chk("R3", "4B@4", v, 64'h2043_4647);
        reg_read(3'd0, 4'd1, v); chk("R3", "1B@0", v, 64'h51);
        reg_read(3'd2, 4'd2, v); chk("R3", "2B@2", v, 64'h4D55);
        reg_read(3'd6, 4'd4, v); chk("R3", "4B@6 overruns", v, 64'h0);
    endtask

    task automatic t_read_split();
        fill(8'h40, 8, 8'hEE);
        put_desc(8'h10, C_SL | C_RD, 6, 8'h40);
        reg_write(3'd0, 4'd4, 64'h0);
        chk("R1", "high half alone does not start", {63'd0, busy}, 64'd0);
        reg_write(3'd4, 4'd4, 64'h10);
        chk("R1", "low half starts", {63'd0, busy}, 64'd1);
        wait_idle("R1");
        for (int k = 0; k < 4; k++) chk("R7", "item byte copied", bmem[8'h40 + k], imem[0][k]);
        chk("R7", "zero fill byte 4", bmem[8'h44], 8'h00);
        chk("R7", "zero fill byte 5", bmem[8'h45], 8'h00);
        chk("R4", "length respected", bmem[8'h46], 8'hEE);
        chk("R10", "status success", get_word(8'h10), 32'h0);
        chk("R5", "selector applied", cur_key, 16'd0);
    endtask

    task automatic t_ignored_and_skip();
        put_desc(8'h20, (32'd1 << 16) | C_SL | C_SK, 2, 8'h60);
        reg_write(3'd4, 4'd2, 64'h20); chk("R2", "2B@4 ignored", {63'd0, busy}, 64'd0);
        reg_write(3'd2, 4'd4, 64'h20); chk("R2", "4B@2 ignored", {63'd0, busy}, 64'd0);
        reg_write(3'd4, 4'd8, 64'h20); chk("R2", "8B@4 ignored", {63'd0, busy}, 64'd0);
        reg_write(3'd4, 4'd1, 64'h20); chk("R2", "1B@4 ignored", {63'd0, busy}, 64'd0);
        fill(8'h60, 4, 8'hEE);
        reg_write(3'd0, 4'd8, 64'h20);
        chk("R2", "8B@0 starts", {63'd0, busy}, 64'd1);
        wait_idle("R2");
        chk("R8", "skip touches no memory", bmem[8'h60], 8'hEE);
        chk("R8", "skip status", get_word(8'h20), 32'h0);
        put_desc(8'h30, C_RD, 3, 8'h60);
        reg_write(3'd0, 4'd8, 64'h30);
        wait_idle("R8");
        chk("R8", "read after skip b0", bmem[8'h60], imem[1][2]);
        chk("R8", "read after skip b2", bmem[8'h62], imem[1][4]);
    endtask

    task automatic t_priority();
        bmem[8'h70] = 8'h55; bmem[8'h71] = 8'h66;
        put_desc(8'h10, C_SL | C_RD | C_WR | C_SK, 2, 8'h70);
        reg_write(3'd0, 4'd8, 64'h10); wait_idle("R6");
        chk("R6", "read wins byte0", bmem[8'h70], imem[0][0]);
        chk("R6", "read wins status", get_word(8'h10), 32'h0);
        bmem[8'h78] = 8'h11; bmem[8'h79] = 8'h22;
        put_desc(8'h10, (32'd3 << 16) | C_SL | C_WR | C_SK, 2, 8'h78);
        reg_write(3'd0, 4'd8, 64'h10); wait_idle("R6");
        chk("R6", "write beats skip", {imem[3][0], imem[3][1], imem[3][2]}, 64'h1122C2);
        fill(8'h70, 4, 8'h5A);
        put_desc(8'h10, (32'd1 << 16) | C_SL, 4, 8'h70);
        reg_write(3'd0, 4'd8, 64'h10); wait_idle("R6");
        chk("R6", "no op flag: memory untouched", get_word(8'h70), 32'h5A5A5A5A);
        chk("R6", "no op flag: status", get_word(8'h10), 32'h0);
    endtask

    task automatic t_write();
        for (int k = 0; k < 6; k++) bmem[8'h80 + k] = 8'(k + 1);
        put_desc(8'h10, (32'd1 << 16) | C_SL | C_WR, 6, 8'h80);
        reg_write(3'd0, 4'd8, 64'h10); wait_idle("R9");
        chk("R9", "item written", {imem[1][0], imem[1][1], imem[1][2], imem[1][3], imem[1][4], imem[1][5]},
            64'h010203040506);
        chk("R9", "write status ok", get_word(8'h10), 32'h0);
        put_desc(8'h10, C_SL | C_WR, 1, 8'h80);
        reg_write(3'd0, 4'd8, 64'h10); wait_idle("R9");
        chk("R9", "read-only status", get_word(8'h10), 32'h1);
        chk("R9", "read-only item kept", imem[0][0], 8'hA0);
        put_desc(8'h10, (32'd3 << 16) | C_SL | C_WR, 4, 8'h80);
        reg_write(3'd0, 4'd8, 64'h10); wait_idle("R9");
        chk("R9", "overflow status", get_word(8'h10), 32'h1);
        chk("R9", "overflow item kept", imem[3][0], 8'h11);
        put_desc(8'h10, (32'd5 << 16) | C_SL | C_WR, 1, 8'h80);
        reg_write(3'd0, 4'd8, 64'h10); wait_idle("R9");
        chk("R9", "invalid item status", get_word(8'h10), 32'h1);
    endtask

    task automatic t_busy_and_clear();
        fill(8'hA0, 4, 8'hEE);
        put_desc(8'h10, (32'd1 << 16) | C_SL | C_RD, 6, 8'h90);
        put_desc(8'h30, C_SL | C_RD, 1, 8'hA0);
        reg_write(3'd0, 4'd8, 64'h10);
        reg_write(3'd0, 4'd8, 64'h30);
        wait_idle("R11");
        chk("R11", "write while busy ignored", get_word(8'h30), C_SL | C_RD);
        chk("R11", "second target untouched", bmem[8'hA0], 8'hEE);
        reg_write(3'd0, 4'd4, 64'h1);
        reg_write(3'd4, 4'd4, 64'h10);
        wait_idle("R11");
        reg_write(3'd4, 4'd4, 64'h30);
        wait_idle("R11");
        chk("R11", "address cleared at start", bmem[8'hA0], 8'hA0);
        chk("R11", "cleared-address status", get_word(8'h30), 32'h0);
    endtask

    task automatic t_errors();
        logic [15:0] key_before;
        put_word(8'hF4, (32'd3 << 16) | C_SL | C_RD);
        put_word(8'hF8, 32'd2);
        put_word(8'hFC, 32'd0);
        key_before = cur_key;
        reg_write(3'd0, 4'd8, 64'hF4); wait_idle("R10");
        chk("R10", "fetch error status", get_word(8'hF4), 32'h1);
        chk("R10", "no select on fetch error", cur_key, key_before);
        put_desc(8'h10, (32'd1 << 16) | C_SL | C_RD, 4, 8'hFE);
        reg_write(3'd0, 4'd8, 64'h10); wait_idle("R12");
        chk("R12", "mem error status", get_word(8'h10), 32'h1);
        chk("R12", "bytes before error kept", {bmem[8'hFE], bmem[8'hFF]}, 64'h0102);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) bmem[a] = 8'h00;
        for (int k = 0; k < 8; k++) begin
            imem[0][k] = 8'hA0 + 8'(k); imem[1][k] = 8'hB0 + 8'(k);
            imem[2][k] = 8'h00;         imem[3][k] = 8'hC0 + 8'(k);
        end
        ilen[0] = 4; ilen[1] = 6; ilen[2] = 0; ilen[3] = 3;
        iwr[0] = 0;  iwr[1] = 1;  iwr[2] = 1;  iwr[3] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_signature();
        t_read_split();
        t_ignored_and_skip();
        t_priority();
        t_write();
        t_busy_and_clear();
        t_errors();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule